// File: doc/BRIEF.md
# PCM Codec Power-Save Sequencer

This block decides when a voice PCM codec may run its PLL and analog section and when its serial data output may drive the line. It watches the bit clock and the transmit and receive frame syncs, all sampled by a free-running reference clock. When any monitored line stops toggling, or when a frame sync pulse arrives with no bit-clock rising edge inside it, the block drops the codec into power save. A low level on the power-down pin overrides everything and also shuts down the voltage reference.

When activity returns, the block releases the PLL and waits for the lock input. Once lock is reported, it holds the delayed power-down high for a further settle period and only then enables the PCM output. If lock does not arrive within a timeout, the block flags a lock fault, returns to power save and tries again. The receive sync can be left out of the checks through a static configuration pin.

All thresholds are parameters counted in reference-clock cycles. The asynchronous bit-clock, sync and power-down pins each pass through two-flop synchronisers. The PLL lock input is taken as synchronous to the reference clock.

Top module: `pcm_pwr_seq`

## Requirements
- R1: After reset the state is power-save (`pwrState` = 1), with `pwd`=1, `dpwd`=1, `refPwd`=0, `pcmOutEn`=0 and `lockFault`=0. The state encoding is active=0, power-save=1, power-down=2, wake/settle=3.
- R2: While `powerDownN` is low, the state becomes power-down within 3 cycles, whatever the other inputs are, with `refPwd`=1, `pwd`=1 and `dpwd`=1. Leaving power-down always passes through power-save.
- R3: If the synchronised bit clock shows no edge for `BCLK_TO` cycles, whether it is stuck high or stuck low, any running state falls back to power-save.
- R4: If the synchronised transmit sync shows no rising edge for `SYNC_TO` cycles, any running state falls back to power-save.
- R5: With `rxMonEn`=1 the receive sync is checked by the same rules as the transmit sync (R4, R6). With `rxMonEn`=0 it has no effect on the state.
- R6: A sync pulse that ends without a bit-clock rising edge during its high phase counts as a frame fault and forces power-save. The fault clears at the end of the next pulse that does contain a bit-clock rising edge.
- R7: From power-save, once every monitored line is active and fault-free, the state moves to wake/settle, with `pwd`=0 and `dpwd`=1.
- R8: In wake/settle the state becomes active only after `pllLock` has been high for `SETTLE_CYC` consecutive cycles. A drop of lock restarts the count.
- R9: If lock has not been seen for `LOCK_TO` cycles in wake/settle, `lockFault` rises and the state returns to power-save. `lockFault` clears on reaching active or on power-down.
- R10: `pcmOutEn` is 1 only in the active state, where `dpwd`=0. In every other state the PCM output stays in high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Codec bit clock (asynchronous) |
| txSync | input | 1 | Transmit frame sync (asynchronous) |
| rxSync | input | 1 | Receive frame sync (asynchronous) |
| rxMonEn | input | 1 | Static: 1 includes the receive sync in the checks |
| powerDownN | input | 1 | Active-low full power-down pin (asynchronous) |
| pllLock | input | 1 | PLL lock indication, synchronous to clk |
| pwd | output | 1 | Power-down of PLL and analog section |
| refPwd | output | 1 | Power-down of the voltage reference |
| dpwd | output | 1 | Delayed power-down; holds outputs quiet |
| pcmOutEn | output | 1 | PCM data output drive enable (0 = high impedance) |
| lockFault | output | 1 | PLL lock did not arrive in time |
| pwrState | output | 2 | Current state: 0 active, 1 save, 2 down, 3 wake/settle |

## Verification
The hardest situations to reach from the ports are a lock drop partway through the settle window and a short sync glitch that contains no bit-clock rising edge while everything else looks healthy. The bench drives a small behavioural PLL that follows `pwd` and can be told to drop lock for one cycle at a chosen count after wake. It also drives a frame generator that can insert a two-cycle sync pulse at a fixed phase, where the bit clock is steady high. A behavioural reference model, fed with the same pins, predicts every output on every clock. This lets a restarted settle count or a fault that fails to clear show up at the exact cycle it matters.

// File: rtl/pcm_pwr_pkg.sv
package pcm_pwr_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SAVE   = 2'd1,
    ST_DOWN   = 2'd2,
    ST_WAKE   = 2'd3
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic lockTimerRun;
    logic settleTimerRun;
  } ctlStrobe_t;

  // condensed conditions from datapath to control
  typedef struct packed {
    logic linkOk;
    logic pdnLow;
    logic lockTimeout;
    logic settleDone;
  } dpStatus_t;

endpackage

// File: rtl/pcm_sync2.sv
module pcm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic qPrev
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta  <= 1'b0;
      q     <= 1'b0;
      qPrev <= 1'b0;
    end else begin
      meta  <= din;
      q     <= meta;
      qPrev <= q;
    end
  end
endmodule

// File: rtl/pcm_frame_mon.sv
module pcm_frame_mon #(
  parameter int SYNC_TO = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic syncNow,
  input  logic syncPrev,
  input  logic bclkRise,
  output logic alive,
  output logic fault
);
  localparam int CW = $clog2(SYNC_TO + 1);
  localparam logic [CW-1:0] GAP_LIM = CW'(SYNC_TO);

  logic [CW-1:0] gapCnt;
  logic seenRise;
  logic syncRise, syncFall;

  assign syncRise = syncNow & ~syncPrev;
  assign syncFall = ~syncNow & syncPrev;
  assign alive    = (gapCnt != GAP_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt   <= GAP_LIM;
      seenRise <= 1'b0;
      fault    <= 1'b0;
    end else begin
      if (syncRise)
        gapCnt <= '0;
      else if (gapCnt != GAP_LIM)
        gapCnt <= gapCnt + 1'b1;

      if (syncRise)
        seenRise <= bclkRise;
      else if (syncNow && bclkRise)
        seenRise <= 1'b1;

      if (syncFall)
        fault <= ~seenRise;
    end
  end

  // R6: a frame fault can only appear at the end of a sync pulse
  a_r6_fault_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(syncFall));

endmodule

// File: rtl/pcm_pwr_dp.sv
module pcm_pwr_dp
  import pcm_pwr_pkg::*;
#(
  parameter int BCLK_TO    = 1024,
  parameter int SYNC_TO    = 8192,
  parameter int LOCK_TO    = 500000,
  parameter int SETTLE_CYC = 50000,
  parameter int N_SYNC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       txSync,
  input  logic       rxSync,
  input  logic       rxMonEn,
  input  logic       powerDownN,
  input  logic       pllLock,
  input  ctlStrobe_t strobe,
  output dpStatus_t  status
);
  localparam int BW = $clog2(BCLK_TO + 1);
  localparam int LW = $clog2(LOCK_TO + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [BW-1:0] BCLK_LIM   = BW'(BCLK_TO);
  localparam logic [LW-1:0] LOCK_LIM   = LW'(LOCK_TO);
  localparam logic [SW-1:0] SETTLE_LIM = SW'(SETTLE_CYC);

  // bit clock
  logic bclkNow, bclkPrev, bclkRise, bclkAlive;
  logic [BW-1:0] bclkGap;

  pcm_sync2 u_bclkSync (.clk(clk), .rst_n(rst_n), .din(bclk), .q(bclkNow), .qPrev(bclkPrev));

  assign bclkRise  = bclkNow & ~bclkPrev;
  assign bclkAlive = (bclkGap != BCLK_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bclkGap <= BCLK_LIM;
    else if (bclkNow != bclkPrev)
      bclkGap <= '0;
    else if (bclkGap != BCLK_LIM)
      bclkGap <= bclkGap + 1'b1;
  end

  // frame syncs: index 0 transmit, index 1 receive
  logic [N_SYNC-1:0] syncPin, syncNow, syncPrev, syncAlive, syncFault;
  assign syncPin = {rxSync, txSync};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    pcm_sync2 u_sync (.clk(clk), .rst_n(rst_n), .din(syncPin[g]),
                      .q(syncNow[g]), .qPrev(syncPrev[g]));
    pcm_frame_mon #(.SYNC_TO(SYNC_TO)) u_mon (
      .clk(clk), .rst_n(rst_n), .syncNow(syncNow[g]), .syncPrev(syncPrev[g]),
      .bclkRise(bclkRise), .alive(syncAlive[g]), .fault(syncFault[g]));
  end

  // power-down pin synchroniser, resets to "not powered down"
  logic pdnMeta, pdnSync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdnMeta <= 1'b1;
      pdnSync <= 1'b1;
    end else begin
      pdnMeta <= powerDownN;
      pdnSync <= pdnMeta;
    end
  end

  // lock wait and settle timers
  logic [LW-1:0] lockCnt;
  logic [SW-1:0] settleCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lockCnt   <= '0;
      settleCnt <= '0;
    end else begin
      if (!strobe.lockTimerRun)
        lockCnt <= '0;
      else if (!pllLock && lockCnt != LOCK_LIM)
        lockCnt <= lockCnt + 1'b1;

      if (!strobe.settleTimerRun || !pllLock)
        settleCnt <= '0;
      else if (settleCnt != SETTLE_LIM)
        settleCnt <= settleCnt + 1'b1;
    end
  end

  logic rxOk;
  assign rxOk = !rxMonEn || (syncAlive[1] && !syncFault[1]);

  assign status.linkOk      = bclkAlive && syncAlive[0] && !syncFault[0] && rxOk;
  assign status.pdnLow      = !pdnSync;
  assign status.lockTimeout = (lockCnt == LOCK_LIM);
  assign status.settleDone  = (settleCnt == SETTLE_LIM);

  // R3: a bit-clock edge always revives the bit-clock monitor
  a_r3_edge_revives: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bclkNow != bclkPrev) |-> bclkAlive);

endmodule

// File: rtl/pcm_pwr_ctl.sv
module pcm_pwr_ctl
  import pcm_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output pwrState_t  state,
  output logic       lockFault
);
  pwrState_t nxt;
  logic faultNxt;

  always_comb begin
    nxt      = state;
    faultNxt = lockFault;
    if (status.pdnLow) begin
      nxt      = ST_DOWN;
      faultNxt = 1'b0;
    end else begin
      case (state)
        ST_DOWN: nxt = ST_SAVE;
        ST_SAVE: if (status.linkOk) nxt = ST_WAKE;
        ST_WAKE: begin
          if (!status.linkOk) begin
            nxt = ST_SAVE;
          end else if (status.lockTimeout) begin
            nxt      = ST_SAVE;
            faultNxt = 1'b1;
          end else if (status.settleDone) begin
            nxt      = ST_ACTIVE;
            faultNxt = 1'b0;
          end
        end
        ST_ACTIVE: if (!status.linkOk) nxt = ST_SAVE;
        default: nxt = ST_SAVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SAVE;
      lockFault <= 1'b0;
    end else begin
      state     <= nxt;
      lockFault <= faultNxt;
    end
  end

  assign strobe.lockTimerRun   = (state == ST_WAKE);
  assign strobe.settleTimerRun = (state == ST_WAKE);

  a_r2_down_priority: assert property (@(posedge clk) disable iff (!rst_n)
    status.pdnLow |=> (state == ST_DOWN));

  a_r7_wake_from_save: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && $past(state) != ST_WAKE) |-> $past(state) == ST_SAVE);

  a_r8_active_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |-> $past(status.settleDone));

  a_r9_fault_from_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockFault) |-> (state == ST_SAVE && $past(state) == ST_WAKE));

endmodule

// File: rtl/pcm_pwr_seq.sv
module pcm_pwr_seq
  import pcm_pwr_pkg::*;
#(
  parameter int BCLK_TO    = 1024,
  parameter int SYNC_TO    = 8192,
  parameter int LOCK_TO    = 500000,
  parameter int SETTLE_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       txSync,
  input  logic       rxSync,
  input  logic       rxMonEn,
  input  logic       powerDownN,
  input  logic       pllLock,
  output logic       pwd,
  output logic       refPwd,
  output logic       dpwd,
  output logic       pcmOutEn,
  output logic       lockFault,
  output logic [1:0] pwrState
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  pwrState_t  state;

  pcm_pwr_dp #(
    .BCLK_TO(BCLK_TO), .SYNC_TO(SYNC_TO), .LOCK_TO(LOCK_TO), .SETTLE_CYC(SETTLE_CYC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .txSync(txSync), .rxSync(rxSync),
    .rxMonEn(rxMonEn), .powerDownN(powerDownN), .pllLock(pllLock),
    .strobe(strobe), .status(status));

  pcm_pwr_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .status(status), .strobe(strobe),
    .state(state), .lockFault(lockFault));

  assign pwrState = state;
  assign pwd      = (state == ST_SAVE) || (state == ST_DOWN);
  assign refPwd   = (state == ST_DOWN);
  assign dpwd     = (state != ST_ACTIVE);
  assign pcmOutEn = (state == ST_ACTIVE);

  // R10: the output only ever turns on straight out of the settle phase
  a_r10_oe_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcmOutEn) |-> ($past(state) == ST_WAKE));

endmodule

// File: tb/pcm_pwr_seq_tb.sv
module pcm_pwr_seq_tb;
  localparam int BTO = 16, STO = 200, LTO = 150, SET = 40, FRAME = 128;
  localparam int S_ACT = 0, S_SAVE = 1, S_DOWN = 2, S_WAKE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, txSync = 1'b0, rxSync = 1'b0, rxMonEn = 1'b1;
  logic powerDownN = 1'b1, pllLock = 1'b0;
  logic pwd, refPwd, dpwd, pcmOutEn, lockFault;
  logic [1:0] pwrState;

  always #10 clk = ~clk;

  pcm_pwr_seq #(.BCLK_TO(BTO), .SYNC_TO(STO), .LOCK_TO(LTO), .SETTLE_CYC(SET)) u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .txSync(txSync), .rxSync(rxSync),
    .rxMonEn(rxMonEn), .powerDownN(powerDownN), .pllLock(pllLock),
    .pwd(pwd), .refPwd(refPwd), .dpwd(dpwd), .pcmOutEn(pcmOutEn),
    .lockFault(lockFault), .pwrState(pwrState));

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- stimulus generator and PLL model ----------------
  bit bclkRun = 0, bclkHold = 0, txRun = 0, rxRun = 0;
  bit glitchReq = 0, glitchDone = 0;
  int genPh = 0, pc = 0, lockDelay = 20, dropAt = -1;

  // ---------------- reference model state ----------------
  int mB[3], mT[3], mR[3], mP[2];
  int bC, tC, rC, tSeen, tFault, rSeen, rFault, lockC, setC, mState, mFault;

  always @(posedge clk or negedge rst_n) begin : model
    bit bEdge, bRise, tRise, tFall, rRise, rFall, link, tmo, sdone, wake;
    int nS, nF;
    if (!rst_n) begin
      mB = '{0, 0, 0}; mT = '{0, 0, 0}; mR = '{0, 0, 0}; mP = '{1, 1};
      bC = BTO; tC = STO; rC = STO; tSeen = 0; tFault = 0; rSeen = 0; rFault = 0;
      lockC = 0; setC = 0; mState = S_SAVE; mFault = 0;
    end else begin
      bEdge = mB[1] != mB[2];
      bRise = mB[1] == 1 && mB[2] == 0;
      tRise = mT[1] == 1 && mT[2] == 0;  tFall = mT[1] == 0 && mT[2] == 1;
      rRise = mR[1] == 1 && mR[2] == 0;  rFall = mR[1] == 0 && mR[2] == 1;
      link = (bC < BTO) && (tC < STO) && !tFault &&
             (!rxMonEn || ((rC < STO) && !rFault));
      tmo = lockC >= LTO;
      sdone = setC >= SET;
      wake = mState == S_WAKE;
      nS = mState; nF = mFault;
      if (mP[1] == 0) begin nS = S_DOWN; nF = 0; end
      else if (mState == S_DOWN) nS = S_SAVE;
      else if (mState == S_SAVE) begin if (link) nS = S_WAKE; end
      else if (mState == S_ACT) begin if (!link) nS = S_SAVE; end
      else begin
        if (!link) nS = S_SAVE;
        else if (tmo) begin nS = S_SAVE; nF = 1; end
        else if (sdone) begin nS = S_ACT; nF = 0; end
      end
      bC = bEdge ? 0 : (bC < BTO ? bC + 1 : bC);
      tC = tRise ? 0 : (tC < STO ? tC + 1 : tC);
      rC = rRise ? 0 : (rC < STO ? rC + 1 : rC);
      if (tRise) tSeen = bRise; else if (mT[1] == 1 && bRise) tSeen = 1;
      if (tFall) tFault = !tSeen;
      if (rRise) rSeen = bRise; else if (mR[1] == 1 && bRise) rSeen = 1;
      if (rFall) rFault = !rSeen;
      if (!wake) lockC = 0; else if (!pllLock && lockC < LTO) lockC++;
      if (!wake || !pllLock) setC = 0; else if (setC < SET) setC++;
      mB[2] = mB[1]; mB[1] = mB[0]; mB[0] = bclk;
      mT[2] = mT[1]; mT[1] = mT[0]; mT[0] = txSync;
      mR[2] = mR[1]; mR[1] = mR[0]; mR[0] = rxSync;
      mP[1] = mP[0]; mP[0] = powerDownN;
      mState = nS; mFault = nF;
    end
  end

  // compare, then drive, on every falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        chk("R7 state vs model", int'(pwrState), mState);
        chk("R9 lockFault vs model", int'(lockFault), mFault);
        chk("R2 refPwd vs model", int'(refPwd), int'(mState == S_DOWN));
        chk("R10 pcmOutEn vs model", int'(pcmOutEn), int'(mState == S_ACT));
        chk("R7 pwd vs model", int'(pwd), int'(mState == S_SAVE || mState == S_DOWN));
      end
      genPh = (genPh == FRAME - 1) ? 0 : genPh + 1;
      bclk   = bclkRun ? ((genPh % 8) < 4) : bclkHold;
      txSync = txRun && (genPh < 8);
      rxSync = rxRun && (genPh < 8);
      if (glitchReq && (genPh == 42 || genPh == 43)) begin
        txSync = 1'b1;
        if (genPh == 43) begin glitchReq = 0; glitchDone = 1; end
      end
      if (pwd) begin pc = 0; pllLock = 1'b0; end
      else begin pc++; pllLock = (pc >= lockDelay) && (pc != dropAt); end
    end
  end

  task automatic waitFor(int st, int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (int'(pwrState) == st) return;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", int'(pwrState), S_SAVE);
    chk("R1 pwd", int'(pwd), 1);
    chk("R1 dpwd", int'(dpwd), 1);
    chk("R1 refPwd", int'(refPwd), 0);
    chk("R1 pcmOutEn", int'(pcmOutEn), 0);

    // R7, R8, R10 normal bring-up
    bclkRun = 1; txRun = 1; rxRun = 1;
    waitFor(S_WAKE, 400);
    chk("R7 wake state", int'(pwrState), S_WAKE);
    chk("R7 wake pwd", int'(pwd), 0);
    chk("R7 wake dpwd", int'(dpwd), 1);
    waitFor(S_ACT, 200);
    chk("R8 active", int'(pwrState), S_ACT);
    chk("R10 oe on", int'(pcmOutEn), 1);
    chk("R10 dpwd off", int'(dpwd), 0);

    // R3 bit clock stuck high, then stuck low
    bclkHold = 1; bclkRun = 0;
    repeat (40) @(negedge clk);
    chk("R3 stuck high", int'(pwrState), S_SAVE);
    bclkRun = 1;
    waitFor(S_ACT, 800);
    chk("R3 recover", int'(pwrState), S_ACT);
    bclkHold = 0; bclkRun = 0;
    repeat (40) @(negedge clk);
    chk("R3 stuck low", int'(pwrState), S_SAVE);
    bclkRun = 1;
    waitFor(S_ACT, 800);

    // R4 transmit sync stops
    txRun = 0;
    repeat (260) @(negedge clk);
    chk("R4 tx stopped", int'(pwrState), S_SAVE);
    txRun = 1;
    waitFor(S_ACT, 800);
    chk("R4 recover", int'(pwrState), S_ACT);

    // R5 receive sync monitored, then ignored
    rxRun = 0;
    repeat (260) @(negedge clk);
    chk("R5 rx stopped monitored", int'(pwrState), S_SAVE);
    rxMonEn = 0;
    waitFor(S_ACT, 800);
    chk("R5 rx ignored", int'(pwrState), S_ACT);
    rxRun = 1;
    repeat (300) @(negedge clk);
    rxMonEn = 1;
    repeat (20) @(negedge clk);
    chk("R5 rx back", int'(pwrState), S_ACT);

    // R6 sync glitch with no bit-clock rise
    glitchDone = 0; glitchReq = 1;
    while (!glitchDone) @(negedge clk);
    repeat (8) @(negedge clk);
    chk("R6 glitch save", int'(pwrState), S_SAVE);
    waitFor(S_ACT, 800);
    chk("R6 recover", int'(pwrState), S_ACT);

    // R8 lock drop in the settle window restarts it
    dropAt = 40;
    bclkRun = 0;
    repeat (40) @(negedge clk);
    bclkRun = 1;
    waitFor(S_WAKE, 600);
    repeat (70) @(negedge clk);
    chk("R8 settle restarted", int'(pwrState), S_WAKE);
    repeat (30) @(negedge clk);
    chk("R8 active after restart", int'(pwrState), S_ACT);
    dropAt = -1;

    // R9 lock timeout
    lockDelay = 1000000;
    bclkRun = 0;
    repeat (40) @(negedge clk);
    bclkRun = 1;
    repeat (600) @(negedge clk);
    chk("R9 fault set", int'(lockFault), 1);
    chk("R9 output off", int'(pcmOutEn), 0);
    lockDelay = 20;
    waitFor(S_ACT, 600);
    chk("R9 fault cleared", int'(lockFault), 0);
    chk("R9 active", int'(pwrState), S_ACT);

    // R2 power-down pin overrides running activity
    powerDownN = 0;
    repeat (5) @(negedge clk);
    chk("R2 down state", int'(pwrState), S_DOWN);
    chk("R2 refPwd", int'(refPwd), 1);
    chk("R2 dpwd", int'(dpwd), 1);
    powerDownN = 1;
    waitFor(S_ACT, 800);
    chk("R2 recover", int'(pwrState), S_ACT);

    done = 1;
    summary();
  end
endmodule